// File: doc/BRIEF.md
# Preemptive SRAM Access Arbiter with Clock Stretch

This block decides which of two ports, the I2C host port or the RF reader port, owns the shared memory at any moment. In its health-device exchange mode, an RF request for the SRAM may interrupt an I2C transfer to that SRAM while the transfer is still running. The I2C byte in flight is allowed to finish. The arbiter then asks the I2C slave logic to stretch the clock, moves the lock to the RF port, and gives the lock back to I2C once the RF command finishes. The I2C host sees only a longer clock-low phase and continues its transfer unchanged.

In every other mode, and for memory outside the SRAM window, ownership is first come first served. A port that asks while the other port holds the lock is refused, and the refusal is reported for that cycle. Protocol decoding and the line drivers sit outside this block. It takes decoded request, byte-boundary and completion strobes and returns lock flags, a stretch request and refusal flags.

Top module: `sram_preempt_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, `i2c_locked`, `rf_locked` and `clk_stretch` are all 0.
- R2: Preemption is enabled only when `mode_sel` equals 2'b11 and `rf_field_ok`, `vcc_ok` and `sram_en` are all 1. When it is not enabled, an `rf_req` made while I2C owns the lock raises `rf_refuse` in that cycle and leaves both locks unchanged.
- R3: An I2C address hits the SRAM when it is in 0000h–003Fh (the mirrored blocks) or in 2000h–203Fh. An RF access hits the SRAM when `rf_sram_cmd` is 1 or `rf_blk` is below 40h. Only a hit on both sides, with `i2c_busy` high, can trigger preemption.
- R4: When no port owns the lock, the first requester holds its lock from the next cycle on. If both ports request in the same cycle, I2C wins. An RF request is taken from idle only while `rf_field_ok` is 1.
- R5: A preemption that is accepted without `i2c_byte_done` keeps `i2c_locked` at 1 and `clk_stretch` at 0 until the cycle in which `i2c_byte_done` is 1.
- R6: In the cycle after the byte boundary (the acceptance cycle, or a later cycle, that has `i2c_byte_done` = 1), `clk_stretch` = 1, `i2c_locked` = 0 and `rf_locked` = 1.
- R7: `clk_stretch` stays at 1 on every cycle until the cycle after `rf_done` or after a loss of `rf_field_ok`.
- R8: In the cycle after `rf_done` during preemption, `i2c_locked` = 1, `rf_locked` = 0 and `clk_stretch` = 0.
- R9: If `rf_field_ok` is 0 while a preemption is pending or in progress, the next cycle has `i2c_locked` = 1 and `rf_locked` = 0 and `clk_stretch` = 0.
- R10: `i2c_locked` and `rf_locked` are never 1 together.
- R11: `i2c_release` frees an I2C-held lock on the next cycle, and this takes precedence over a preemption request in the same cycle. `rf_done` or field loss frees an RF lock obtained from idle. An `i2c_req` made while RF holds a lock obtained from idle raises `i2c_refuse` in that cycle.
- R12: An RF request that does not hit the SRAM, made while I2C owns the lock, is refused even with preemption enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Arbitration mode; 2'b11 selects the preemptive mode |
| rf_field_ok | input | 1 | RF field present |
| vcc_ok | input | 1 | External supply present |
| sram_en | input | 1 | SRAM enabled |
| i2c_req | input | 1 | I2C port is addressed for a memory access |
| i2c_release | input | 1 | I2C host ends its ownership |
| i2c_busy | input | 1 | I2C memory transfer in progress |
| i2c_addr | input | 16 | Current I2C memory address |
| i2c_byte_done | input | 1 | Strobe at the end of an I2C byte |
| rf_req | input | 1 | Valid RF command addressing memory |
| rf_sram_cmd | input | 1 | RF command is a dedicated SRAM read or write |
| rf_blk | input | 8 | RF block address |
| rf_done | input | 1 | RF command complete |
| i2c_locked | output | 1 | I2C port owns memory |
| rf_locked | output | 1 | RF port owns memory |
| clk_stretch | output | 1 | Request to hold the I2C clock low |
| rf_refuse | output | 1 | RF request refused this cycle |
| i2c_refuse | output | 1 | I2C request refused this cycle |

## Verification
The bench builds the block with its default parameters: a 64-block SRAM window, 16-bit I2C addresses based at 2000h and 8-bit RF block numbers. With these values, random addresses land on both windows, on the edges just outside them and on unrelated memory, so hits and misses both occur. Random bursts of byte strobes, RF completions and field drops drive the arbiter through every path between waiting for a byte boundary, stretching and resuming. Directed sequences pin down same-cycle corners: a byte strobe in the same cycle as acceptance, a release in the same cycle as a preemption request, and simultaneous requests from idle.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;

    localparam int unsigned ADDR_W      = 16;
    localparam int unsigned BLK_W       = 8;
    localparam int unsigned SRAM_BLOCKS = 64;
    localparam logic [1:0]  MODE_PREEMPT = 2'b11;

    typedef enum logic [2:0] {
        ARB_IDLE,
        ARB_I2C,
        ARB_WAIT_BYTE,
        ARB_RF_PREEMPT,
        ARB_RF
    } arb_state_e;

    typedef struct packed {
        logic i2c_hit;
        logic rf_hit;
    } sram_hit_t;

    function automatic logic in_window(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] size);
        return (addr >= base) && (addr < base + size);
    endfunction

endpackage

// File: rtl/sram_arb_window.sv
module sram_arb_window
    import sram_arb_pkg::*;
#(
    parameter int unsigned AW        = ADDR_W,
    parameter int unsigned BW        = BLK_W,
    parameter int unsigned NBLK      = SRAM_BLOCKS,
    parameter logic [AW-1:0] I2C_BASE = 16'h2000
) (
    input  logic [AW-1:0] i2c_addr,
    input  logic [BW-1:0] rf_blk,
    input  logic          rf_sram_cmd,
    output sram_hit_t     hit
);
    localparam logic [31:0] BASE32 = 32'(I2C_BASE);
    localparam logic [31:0] SIZE32 = 32'(NBLK);

    always_comb begin
        hit.i2c_hit = in_window(32'(i2c_addr), 32'd0, SIZE32)
                   || in_window(32'(i2c_addr), BASE32, SIZE32);
        hit.rf_hit  = rf_sram_cmd || in_window(32'(rf_blk), 32'd0, SIZE32);
    end
endmodule

// File: rtl/sram_arb_fsm.sv
module sram_arb_fsm
    import sram_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      preempt_en,
    input  logic      rf_field_ok,
    input  sram_hit_t hit,
    input  logic      i2c_req,
    input  logic      i2c_release,
    input  logic      i2c_busy,
    input  logic      i2c_byte_done,
    input  logic      rf_req,
    input  logic      rf_done,
    output logic      i2c_locked,
    output logic      rf_locked,
    output logic      clk_stretch,
    output logic      rf_refuse,
    output logic      i2c_refuse
);
    arb_state_e state_q, state_d;
    logic       go_preempt;

    assign go_preempt = preempt_en && rf_req && hit.rf_hit
                     && i2c_busy && hit.i2c_hit && !i2c_release;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (i2c_req)                  state_d = ARB_I2C;
                else if (rf_req && rf_field_ok) state_d = ARB_RF;
            end
            ARB_I2C: begin
                if (i2c_release)              state_d = ARB_IDLE;
                else if (go_preempt)
                    state_d = i2c_byte_done ? ARB_RF_PREEMPT : ARB_WAIT_BYTE;
            end
            ARB_WAIT_BYTE: begin
                if (!rf_field_ok)             state_d = ARB_I2C;
                else if (i2c_byte_done)       state_d = ARB_RF_PREEMPT;
            end
            ARB_RF_PREEMPT: begin
                if (!rf_field_ok || rf_done)  state_d = ARB_I2C;
            end
            ARB_RF: begin
                if (!rf_field_ok || rf_done)  state_d = ARB_IDLE;
            end
            default:                          state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ARB_IDLE;
        else     state_q <= state_d;
    end

    assign i2c_locked  = (state_q == ARB_I2C) || (state_q == ARB_WAIT_BYTE);
    assign rf_locked   = (state_q == ARB_RF)  || (state_q == ARB_RF_PREEMPT);
    assign clk_stretch = (state_q == ARB_RF_PREEMPT);
    assign rf_refuse   = rf_req && (state_q == ARB_I2C) && !go_preempt;
    assign i2c_refuse  = i2c_req && (state_q == ARB_RF);

    AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(i2c_locked && rf_locked)); // R10
    AST_STRETCH_NEEDS_RF: assert property (@(posedge clk) disable iff (rst)
        clk_stretch |-> rf_locked); // R6
    AST_STRETCH_AT_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stretch) |-> $past(i2c_byte_done)); // R5
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (clk_stretch && !rf_done && rf_field_ok) |=> clk_stretch); // R7
    AST_RESUME: assert property (@(posedge clk) disable iff (rst)
        (clk_stretch && rf_done) |=> (i2c_locked && !rf_locked && !clk_stretch)); // R8
    AST_FIELD_ABORT: assert property (@(posedge clk) disable iff (rst)
        ((clk_stretch || (i2c_locked && $past(go_preempt) && !$past(i2c_byte_done) && !$past(rst)))
         && !rf_field_ok) |=> (i2c_locked && !rf_locked)); // R9
endmodule

// File: rtl/sram_preempt_arbiter.sv
module sram_preempt_arbiter
    import sram_arb_pkg::*;
#(
    parameter int unsigned AW        = ADDR_W,
    parameter int unsigned BW        = BLK_W,
    parameter int unsigned NBLK      = SRAM_BLOCKS,
    parameter logic [AW-1:0] I2C_BASE = 16'h2000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_sel,
    input  logic          rf_field_ok,
    input  logic          vcc_ok,
    input  logic          sram_en,
    input  logic          i2c_req,
    input  logic          i2c_release,
    input  logic          i2c_busy,
    input  logic [AW-1:0] i2c_addr,
    input  logic          i2c_byte_done,
    input  logic          rf_req,
    input  logic          rf_sram_cmd,
    input  logic [BW-1:0] rf_blk,
    input  logic          rf_done,
    output logic          i2c_locked,
    output logic          rf_locked,
    output logic          clk_stretch,
    output logic          rf_refuse,
    output logic          i2c_refuse
);
    sram_hit_t hit;
    logic      preempt_en;

    assign preempt_en = (mode_sel == MODE_PREEMPT) && rf_field_ok && vcc_ok && sram_en;

    sram_arb_window #(.AW(AW), .BW(BW), .NBLK(NBLK), .I2C_BASE(I2C_BASE)) u_window (
        .i2c_addr    (i2c_addr),
        .rf_blk      (rf_blk),
        .rf_sram_cmd (rf_sram_cmd),
        .hit         (hit)
    );

    sram_arb_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .preempt_en    (preempt_en),
        .rf_field_ok   (rf_field_ok),
        .hit           (hit),
        .i2c_req       (i2c_req),
        .i2c_release   (i2c_release),
        .i2c_busy      (i2c_busy),
        .i2c_byte_done (i2c_byte_done),
        .rf_req        (rf_req),
        .rf_done       (rf_done),
        .i2c_locked    (i2c_locked),
        .rf_locked     (rf_locked),
        .clk_stretch   (clk_stretch),
        .rf_refuse     (rf_refuse),
        .i2c_refuse    (i2c_refuse)
    );

    AST_REFUSE_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(rf_refuse && i2c_refuse)); // R11
endmodule

// File: tb/test_sram_preempt_arbiter.sv
module test_sram_preempt_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] mode_sel = 2'b11;
    logic rf_field_ok = 1'b1, vcc_ok = 1'b1, sram_en = 1'b1;
    logic i2c_req = 0, i2c_release = 0, i2c_busy = 0, i2c_byte_done = 0;
    logic [15:0] i2c_addr = 16'h0;
    logic rf_req = 0, rf_sram_cmd = 0, rf_done = 0;
    logic [7:0] rf_blk = 8'h80;
    logic i2c_locked, rf_locked, clk_stretch, rf_refuse, i2c_refuse;

    int errors = 0, checks = 0;
    bit finished = 0;
    // model state: 0 idle, 1 i2c, 2 wait byte, 3 rf preempt, 4 rf
    int ms = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_preempt_arbiter i_sram_preempt_arbiter (
        .clk, .rst, .mode_sel, .rf_field_ok, .vcc_ok, .sram_en,
        .i2c_req, .i2c_release, .i2c_busy, .i2c_addr, .i2c_byte_done,
        .rf_req, .rf_sram_cmd, .rf_blk, .rf_done,
        .i2c_locked, .rf_locked, .clk_stretch, .rf_refuse, .i2c_refuse
    );

    function automatic bit m_i2c_hit(input logic [15:0] a);
        return (a < 16'h0040) || (a >= 16'h2000 && a < 16'h2040);
    endfunction

    function automatic bit m_go();
        return (mode_sel == 2'b11) && rf_field_ok && vcc_ok && sram_en && rf_req
            && (rf_sram_cmd || rf_blk < 8'h40) && i2c_busy && m_i2c_hit(i2c_addr)
            && !i2c_release;
    endfunction

    function automatic int m_next();
        case (ms)
            0: return i2c_req ? 1 : ((rf_req && rf_field_ok) ? 4 : 0);
            1: return i2c_release ? 0 : (m_go() ? (i2c_byte_done ? 3 : 2) : 1);
            2: return !rf_field_ok ? 1 : (i2c_byte_done ? 3 : 2);
            3: return (!rf_field_ok || rf_done) ? 1 : 3;
            default: return (!rf_field_ok || rf_done) ? 0 : 4;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b (model state %0d)", tag, what, act, exp, ms);
        end
    endtask

    // Inputs are already set; compare at mid-cycle, then advance the model.
    task automatic cyc(input string tag);
        @(negedge clk);
        #1;
        chk(tag, "i2c_locked", i2c_locked, ms == 1 || ms == 2);
        chk(tag, "rf_locked", rf_locked, ms == 3 || ms == 4);
        chk(tag, "clk_stretch", clk_stretch, ms == 3);
        chk(tag, "rf_refuse", rf_refuse, rf_req && ms == 1 && !m_go());
        chk(tag, "i2c_refuse", i2c_refuse, i2c_req && ms == 4);
        chk("R10", "exclusive", i2c_locked && rf_locked, 1'b0);
        ms = m_next();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        i2c_req = 0; i2c_release = 0; i2c_byte_done = 0;
        rf_req = 0; rf_done = 0; rf_field_ok = 1;
    endtask

    task automatic goto_idle();
        quiet();
        i2c_release = 1; rf_done = 1; cyc("R11");
        quiet(); cyc("R11");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        @(negedge clk); #1;
        chk("R1", "i2c_locked", i2c_locked, 0);
        chk("R1", "rf_locked", rf_locked, 0);
        chk("R1", "clk_stretch", clk_stretch, 0);
        @(negedge clk); rst = 0;
        ms = 0;
        cyc("R1");

        // R4: RF first from idle, then simultaneous requests
        rf_req = 1; cyc("R4"); quiet(); cyc("R4");
        i2c_req = 1; cyc("R11"); quiet(); // refused while RF owns
        rf_done = 1; cyc("R11"); quiet(); cyc("R11");
        i2c_req = 1; rf_req = 1; cyc("R4"); quiet(); cyc("R4");

        // R5 R6 R7 R8: preempt while mid-byte
        i2c_busy = 1; i2c_addr = 16'h0010; rf_req = 1; rf_sram_cmd = 1;
        cyc("R5"); rf_req = 0;
        cyc("R5"); cyc("R5");
        i2c_byte_done = 1; cyc("R6"); i2c_byte_done = 0;
        cyc("R6"); cyc("R7"); cyc("R7");
        rf_done = 1; cyc("R8"); rf_done = 0; cyc("R8");

        // R6: byte strobe in the acceptance cycle, window at 2000h (R3)
        i2c_addr = 16'h203F; rf_sram_cmd = 0; rf_blk = 8'h3F; rf_req = 1; i2c_byte_done = 1;
        cyc("R3"); quiet(); cyc("R6"); rf_done = 1; cyc("R8"); quiet(); cyc("R8");

        // R3: address just outside both windows is refused
        i2c_addr = 16'h2040; rf_req = 1; cyc("R3"); quiet(); cyc("R3");
        i2c_addr = 16'h0040; rf_req = 1; rf_sram_cmd = 1; cyc("R3"); quiet(); cyc("R3");

        // R12: RF miss on SRAM refused
        i2c_addr = 16'h0000; rf_sram_cmd = 0; rf_blk = 8'h40; rf_req = 1; cyc("R12"); quiet(); cyc("R12");

        // R2: mode other than 11 or supply off refuses
        rf_sram_cmd = 1; mode_sel = 2'b10; rf_req = 1; cyc("R2"); quiet(); cyc("R2");
        mode_sel = 2'b11; vcc_ok = 0; rf_req = 1; cyc("R2"); quiet(); cyc("R2");
        vcc_ok = 1; sram_en = 0; rf_req = 1; cyc("R2"); quiet(); cyc("R2");
        sram_en = 1;

        // R9: field loss while waiting for byte, then while stretched
        rf_req = 1; cyc("R9"); quiet(); rf_field_ok = 0; cyc("R9"); quiet(); cyc("R9");
        rf_req = 1; i2c_byte_done = 1; cyc("R9"); quiet(); cyc("R9");
        rf_field_ok = 0; cyc("R9"); quiet(); cyc("R9");

        // R11: release wins over a same-cycle preemption request
        rf_req = 1; i2c_release = 1; cyc("R11"); quiet(); cyc("R11");

        // Random phase
        goto_idle();
        for (int n = 0; n < 3000; n++) begin
            i2c_req       = ($urandom % 4) == 0;
            i2c_release   = ($urandom % 12) == 0;
            i2c_busy      = ($urandom % 4) != 0;
            i2c_byte_done = ($urandom % 3) == 0;
            rf_req        = ($urandom % 3) == 0;
            rf_done       = ($urandom % 4) == 0;
            rf_field_ok   = ($urandom % 10) != 0;
            rf_sram_cmd   = ($urandom % 3) == 0;
            rf_blk        = 8'($urandom % 8'h50);
            case ($urandom % 4)
                0: i2c_addr = 16'($urandom % 16'h48);
                1: i2c_addr = 16'h2000 + 16'($urandom % 16'h48);
                2: i2c_addr = 16'h1FFF;
                default: i2c_addr = 16'($urandom);
            endcase
            mode_sel = (($urandom % 8) == 0) ? 2'($urandom) : 2'b11;
            vcc_ok   = ($urandom % 16) != 0;
            sram_en  = ($urandom % 16) != 0;
            cyc(ms == 3 ? "R7" : (ms == 2 ? "R5" : "R4"));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule